// File: doc/BRIEF.md
# Multi-Device Priority Request Arbiter

This block grants a shared bus to one of eight attached devices. Each device signals its wishes through a small active-low request code. The arbiter keeps a saturating count of outstanding requests per device for a high class and a low class. It converts those counts into a competing priority level taken from a programmable 9-bit configuration word for each device. It then picks one winner, with a separate round-robin pointer per priority level so that tied devices take turns.

A winning device receives a one-hot active-low grant. Alongside the grant come two status lines: one for the class that was served and one that flags a long packet. A long packet also drives an active-low busy line for three cycles. New grants are suppressed while the bus reports busy, while a stop is in force, in the cycle right after a grant, and while an external contender claims the bus. In each of those cycles the present grant stays on the pins.

Devices may also seize and release the bus. A held device raises the arbiter's own outgoing request level to the hold level. All outputs are active-low: a low level is an asserted, strongly driven value, and a high level stands for the released state, which the pad ring turns into a weak pull-up.

Top module: `prio_req_arbiter`

## Requirements
- R1: Each device drives a 3-bit active-low code on `req_n[3d+2:3d]`: 111 idle, 110 low-class request, 101 high-class request, 100 seize, 011 release. Every other pattern is treated as idle and changes nothing.
- R2: Each device has a high counter and a low counter that saturate at 3. A counter rises by one for a matching request code and falls by one when that device is granted in that class. Reset empties both counters.
- R3: When the FIFO-enable bit of a device is 0, its high-class codes are added to its low counter, and the device only ever competes in the low class.
- R4: The configuration word of device d sits at `dev_cfg[9d+8:9d]`. Bits [2:0] hold the high-class priority, [5:3] the low-class priority, [6] the long flag for the high class, [7] the long flag for the low class, and [8] FIFO-enable.
- R5: A device with a nonzero high counter competes at its high priority. Otherwise a nonzero low counter makes it compete at its low priority. Otherwise it offers level 7 (no request). The lowest level wins, and only levels 0 to 5 can be granted.
- R6: Among devices tied at the best level L, the winner is the lowest-indexed device whose index is above pointer[L]. If there is none, the winner is the lowest-indexed tied device. A grant loads pointer[L] with the winner's index, and reset sets every pointer to 0.
- R7: A new grant is possible only when no grant was issued in the previous cycle, and `busy_in_n` and `stop_n` were both high one cycle earlier. It is also suppressed while `other_win` is high. When no grant is possible, `gnt_n` keeps its value. When a grant is possible but no request qualifies, `gnt_n` returns to all ones.
- R8: A request code present for one cycle into rising edge e1 produces its grant on `gnt_n` after edge e4, provided the path is clear. Each grant stays visible for two cycles, and grants follow one another every second cycle.
- R9: With each new grant, `hicls_gnt_n` goes low when the high class was served and `long_gnt_n` goes low when that class's long flag is set. Both hold their values until the next grant.
- R10: A long grant drives `busy_out_n` low after the grant edge and for the two following cycles. A short grant leaves it high.
- R11: A seize code sets the device's hold flag and a release code clears it. `arb_req_n` shows the bit-inverted outgoing level: the best device level, capped at 6 while any device is held, or 7 when there is nothing.
- R12: Reset is synchronous and active-high. It leaves `gnt_n` all ones, `hicls_gnt_n`, `long_gnt_n` and `busy_out_n` high, and `arb_req_n` at 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 24 | Per-device active-low request codes, 3 bits each |
| dev_cfg | input | 72 | Per-device configuration words, 9 bits each |
| busy_in_n | input | 1 | Active-low bus busy from the bus |
| stop_n | input | 1 | Active-low bus stop |
| other_win | input | 1 | High when another contender takes the bus this cycle |
| gnt_n | output | 8 | One-hot active-low device grants |
| hicls_gnt_n | output | 1 | Low when the last grant served the high class |
| long_gnt_n | output | 1 | Low when the last grant is a long packet |
| busy_out_n | output | 1 | Active-low busy stretched over a long packet |
| arb_req_n | output | 3 | Inverted outgoing request level of this arbiter |

## Verification
The assertions take the configuration words as static while requests are in flight. They also assume that `stop_n`, `busy_in_n` and `other_win` change only between clock edges, so a sampled low stop or busy belongs to a whole cycle. The bench loads the configuration before reset is released and never touches it afterwards. It changes every input on the falling edge only and drains all pending requests before it applies the next stimulus, so the counters a property watches never see an unplanned request.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int CODE_W = 3;
  localparam int CFG_W  = 9;
  localparam int PRIO_W = 3;
  localparam logic [PRIO_W-1:0] PRIO_NONE = PRIO_W'((1 << PRIO_W) - 1);
  localparam logic [PRIO_W-1:0] PRIO_HOLD = PRIO_W'((1 << PRIO_W) - 2);

  // pin patterns (active-low) of the device request code
  typedef enum logic [CODE_W-1:0] {
    CODE_IDLE    = 3'b111,
    CODE_LO      = 3'b110,
    CODE_HI      = 3'b101,
    CODE_SEIZE   = 3'b100,
    CODE_RELEASE = 3'b011
  } req_code_e;

  typedef struct packed {
    logic              fifo_en;
    logic              lo_long;
    logic              hi_long;
    logic [PRIO_W-1:0] lo_prio;
    logic [PRIO_W-1:0] hi_prio;
  } dev_cfg_t;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              hi_cls;
    logic              is_long;
  } offer_t;

  // which counter a code feeds: {high, low}
  function automatic logic [1:0] count_up(input logic [CODE_W-1:0] code,
                                          input logic fifo_en);
    logic up_hi, up_lo;
    up_hi = (code == CODE_HI) && fifo_en;
    up_lo = (code == CODE_LO) || ((code == CODE_HI) && !fifo_en);
    return {up_hi, up_lo};
  endfunction

  // level and packet attributes a device presents
  function automatic offer_t make_offer(input dev_cfg_t c, input logic hi_pend,
                                        input logic lo_pend);
    offer_t o;
    if (hi_pend) begin
      o.prio = c.hi_prio; o.hi_cls = 1'b1; o.is_long = c.hi_long;
    end else if (lo_pend) begin
      o.prio = c.lo_prio; o.hi_cls = 1'b0; o.is_long = c.lo_long;
    end else begin
      o.prio = PRIO_NONE; o.hi_cls = 1'b0; o.is_long = 1'b0;
    end
    return o;
  endfunction
endpackage

// File: rtl/arb_dev_slot.sv
module arb_dev_slot
  import prio_arb_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  dev_cfg_t          cfg,
  input  logic              take_hi,
  input  logic              take_lo,
  output offer_t            offer,
  output logic              hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_hi, cnt_lo;
  logic             up_hi, up_lo;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] cur,
                                                input logic up, input logic down);
    logic [CNT_W:0] s;
    s = {1'b0, cur} + (CNT_W+1)'(up);
    if (s > {1'b0, CNT_MAX}) s = {1'b0, CNT_MAX};
    if (down && s != '0) s = s - 1'b1;
    return s[CNT_W-1:0];
  endfunction

  assign {up_hi, up_lo} = count_up(code, cfg.fifo_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_hi <= '0;
      cnt_lo <= '0;
      hold   <= 1'b0;
    end else begin
      cnt_hi <= sat_step(cnt_hi, up_hi, take_hi);
      cnt_lo <= sat_step(cnt_lo, up_lo, take_lo);
      if (code == CODE_SEIZE)        hold <= 1'b1;
      else if (code == CODE_RELEASE) hold <= 1'b0;
    end
  end

  assign offer = make_offer(cfg, cnt_hi != '0, cnt_lo != '0);

  AST_CNT_SAT_HI: assert property (@(posedge clk) disable iff (rst)
    (cnt_hi == CNT_MAX && !take_hi) |=> cnt_hi == CNT_MAX); // R2
  AST_CNT_SAT_LO: assert property (@(posedge clk) disable iff (rst)
    (cnt_lo == CNT_MAX && !take_lo) |=> cnt_lo == CNT_MAX); // R2
  AST_FIFO_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cfg.fifo_en && !take_hi) |=> cnt_hi == $past(cnt_hi)); // R3
  AST_SEIZE_SETS: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_SEIZE) |=> hold); // R11
endmodule

// File: rtl/arb_picker.sv
module arb_picker
  import prio_arb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int DEV_W   = $clog2(NUM_DEV)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  offer_t [NUM_DEV-1:0]    offers,
  input  logic   [NUM_DEV-1:0]    holds,
  input  logic                    grant_evt,
  output logic                    sel_vld,
  output logic   [DEV_W-1:0]      sel_dev,
  output logic                    sel_hi,
  output logic                    sel_long,
  output logic   [PRIO_W-1:0]     sel_prio,
  output logic   [PRIO_W-1:0]     arb_prio_q
);
  localparam int NUM_PRIO = 1 << PRIO_W;

  logic [DEV_W-1:0]  rover [NUM_PRIO];
  logic [PRIO_W-1:0] best, out_lvl;
  logic [DEV_W-1:0]  win;

  function automatic logic [PRIO_W-1:0] min_level(input offer_t [NUM_DEV-1:0] o);
    logic [PRIO_W-1:0] m;
    m = PRIO_NONE;
    for (int d = 0; d < NUM_DEV; d++)
      if (o[d].prio < m) m = o[d].prio;
    return m;
  endfunction

  // first tied device above the rover, else first tied device
  function automatic logic [DEV_W-1:0] tie_pick(input offer_t [NUM_DEV-1:0] o,
                                                input logic [PRIO_W-1:0] lvl,
                                                input logic [DEV_W-1:0] rov);
    logic [DEV_W-1:0] first_any, first_up;
    logic             got_any, got_up;
    first_any = '0; first_up = '0; got_any = 1'b0; got_up = 1'b0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (o[d].prio == lvl) begin
        if (!got_any) begin first_any = DEV_W'(d); got_any = 1'b1; end
        if (!got_up && DEV_W'(d) > rov) begin first_up = DEV_W'(d); got_up = 1'b1; end
      end
    end
    return got_up ? first_up : first_any;
  endfunction

  always_comb begin
    best    = min_level(offers);
    win     = tie_pick(offers, best, rover[best]);
    out_lvl = (|holds && best > PRIO_HOLD) ? PRIO_HOLD : best;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_vld    <= 1'b0;
      sel_dev    <= '0;
      sel_hi     <= 1'b0;
      sel_long   <= 1'b0;
      sel_prio   <= PRIO_NONE;
      arb_prio_q <= PRIO_NONE;
    end else begin
      sel_vld    <= best < PRIO_HOLD;
      sel_dev    <= win;
      sel_hi     <= offers[win].hi_cls;
      sel_long   <= offers[win].is_long;
      sel_prio   <= best;
      arb_prio_q <= out_lvl;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PRIO; p++) begin : g_rover
      always_ff @(posedge clk) begin
        if (rst)                                         rover[p] <= '0;
        else if (grant_evt && sel_prio == PRIO_W'(p))    rover[p] <= sel_dev;
      end
    end
  endgenerate

  AST_ROVER_LOAD: assert property (@(posedge clk) disable iff (rst)
    grant_evt |=> rover[$past(sel_prio)] == $past(sel_dev)); // R6
  AST_HOLD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (|holds) |=> arb_prio_q <= PRIO_HOLD); // R11
  AST_GRANT_REAL: assert property (@(posedge clk) disable iff (rst)
    grant_evt |-> sel_prio < PRIO_HOLD); // R5
endmodule

// File: rtl/arb_grant_stage.sv
module arb_grant_stage #(
  parameter int NUM_DEV    = 8,
  parameter int DEV_W      = $clog2(NUM_DEV),
  parameter int LONG_EXTRA = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_vld,
  input  logic [DEV_W-1:0]   sel_dev,
  input  logic               sel_hi,
  input  logic               sel_long,
  input  logic               busy_in_q,
  input  logic               stop_q,
  input  logic               other_win,
  output logic               new_grant,
  output logic [NUM_DEV-1:0] gnt_q,
  output logic               hi_q,
  output logic               long_q,
  output logic               busy_q
);
  logic                  gnt_last, gnt_poss, long_start;
  logic [LONG_EXTRA-1:0] stretch;

  assign gnt_poss   = !gnt_last && !busy_in_q && !stop_q;
  assign new_grant  = gnt_poss && sel_vld && !other_win;
  assign long_start = new_grant && sel_long;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_last <= 1'b0;
      gnt_q    <= '0;
      hi_q     <= 1'b0;
      long_q   <= 1'b0;
      stretch  <= '0;
      busy_q   <= 1'b0;
    end else begin
      gnt_last <= new_grant;
      if (new_grant) begin
        gnt_q  <= NUM_DEV'(1) << sel_dev;
        hi_q   <= sel_hi;
        long_q <= sel_long;
      end else if (gnt_poss) begin
        gnt_q  <= '0;
      end
      stretch <= long_start ? '1 : (stretch >> 1);
      busy_q  <= long_start || stretch[0];
    end
  end

  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
    new_grant |=> !new_grant); // R7
  AST_BUSY_LONG: assert property (@(posedge clk) disable iff (rst)
    long_start |=> busy_q ##1 busy_q ##1 busy_q); // R10
endmodule

// File: rtl/prio_req_arbiter.sv
module prio_req_arbiter
  import prio_arb_pkg::*;
#(
  parameter int NUM_DEV    = 8,
  parameter int CNT_W      = 2,
  parameter int LONG_EXTRA = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_DEV*CODE_W-1:0] req_n,
  input  logic [NUM_DEV*CFG_W-1:0]  dev_cfg,
  input  logic                      busy_in_n,
  input  logic                      stop_n,
  input  logic                      other_win,
  output logic [NUM_DEV-1:0]        gnt_n,
  output logic                      hicls_gnt_n,
  output logic                      long_gnt_n,
  output logic                      busy_out_n,
  output logic [PRIO_W-1:0]         arb_req_n
);
  localparam int DEV_W = $clog2(NUM_DEV);

  logic [CODE_W-1:0]    code_q [NUM_DEV];
  logic                 busy_in_q, stop_q;
  offer_t [NUM_DEV-1:0] offers;
  logic [NUM_DEV-1:0]   holds;
  logic                 sel_vld, sel_hi, sel_long, new_grant;
  logic [DEV_W-1:0]     sel_dev;
  logic [PRIO_W-1:0]    sel_prio, arb_prio_q;
  logic [NUM_DEV-1:0]   gnt_q;
  logic                 hi_q, long_q, busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_in_q <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      busy_in_q <= !busy_in_n;
      stop_q    <= !stop_n;
    end
  end

  generate
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
      logic take_hi, take_lo;
      assign take_hi = new_grant && sel_dev == DEV_W'(g) && sel_hi;
      assign take_lo = new_grant && sel_dev == DEV_W'(g) && !sel_hi;

      always_ff @(posedge clk) begin
        if (rst) code_q[g] <= CODE_IDLE;
        else     code_q[g] <= req_n[g*CODE_W +: CODE_W];
      end

      arb_dev_slot #(.CNT_W(CNT_W)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .code    (code_q[g]),
        .cfg     (dev_cfg_t'(dev_cfg[g*CFG_W +: CFG_W])),
        .take_hi (take_hi),
        .take_lo (take_lo),
        .offer   (offers[g]),
        .hold    (holds[g])
      );
    end
  endgenerate

  arb_picker #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_pick (
    .clk        (clk),
    .rst        (rst),
    .offers     (offers),
    .holds      (holds),
    .grant_evt  (new_grant),
    .sel_vld    (sel_vld),
    .sel_dev    (sel_dev),
    .sel_hi     (sel_hi),
    .sel_long   (sel_long),
    .sel_prio   (sel_prio),
    .arb_prio_q (arb_prio_q)
  );

  arb_grant_stage #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .LONG_EXTRA(LONG_EXTRA)) u_gnt (
    .clk       (clk),
    .rst       (rst),
    .sel_vld   (sel_vld),
    .sel_dev   (sel_dev),
    .sel_hi    (sel_hi),
    .sel_long  (sel_long),
    .busy_in_q (busy_in_q),
    .stop_q    (stop_q),
    .other_win (other_win),
    .new_grant (new_grant),
    .gnt_q     (gnt_q),
    .hi_q      (hi_q),
    .long_q    (long_q),
    .busy_q    (busy_q)
  );

  assign gnt_n       = ~gnt_q;
  assign hicls_gnt_n = ~hi_q;
  assign long_gnt_n  = ~long_q;
  assign busy_out_n  = ~busy_q;
  assign arb_req_n   = ~arb_prio_q;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~gnt_n)); // R6
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !stop_n |-> ##2 $stable(gnt_n)); // R7
  AST_BUSYIN_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !busy_in_n |-> ##2 $stable(gnt_n)); // R7
  AST_OTHER_BLOCK: assert property (@(posedge clk) disable iff (rst)
    other_win |=> ($stable(gnt_n) || (&gnt_n))); // R7
endmodule

// File: tb/sim_prio_req_arbiter.sv
module sim_prio_req_arbiter;
  localparam int ND = 8;
  localparam logic [2:0] C_ID = 3'b111, C_LO = 3'b110, C_HI = 3'b101,
                         C_SZ = 3'b100, C_RL = 3'b011, C_BAD = 3'b000;
  localparam logic [23:0] IDLE_W = {8{C_ID}};
  // {fifo_en, lo_long, hi_long, lo_prio[2:0], hi_prio[2:0]}
  localparam logic [8:0] CFG_TAB [ND] = '{
    9'b1_0_1_100_001, 9'b1_1_0_100_001, 9'b1_0_1_011_010, 9'b1_1_0_101_000,
    9'b1_0_1_100_001, 9'b0_1_0_011_010, 9'b1_0_1_100_001, 9'b1_1_0_101_000 };
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {C_HI,C_ID,C_ID,C_ID,C_HI,C_ID,C_ID,C_ID},
    {C_ID,C_LO,C_ID,C_LO,C_ID,C_ID,C_LO,C_LO},
    {C_ID,C_ID,C_HI,C_ID,C_ID,C_HI,C_ID,C_ID},
    {8{C_LO}},
    {8{C_HI}},
    {C_ID,C_HI,C_ID,C_HI,C_ID,C_ID,C_LO,C_HI},
    {C_LO,C_HI,C_LO,C_HI,C_LO,C_HI,C_LO,C_HI} };

  logic        clk = 1'b0, rst = 1'b1;
  logic [23:0] req_n = IDLE_W;
  logic [71:0] dev_cfg;
  logic        busy_in_n = 1'b1, stop_n = 1'b1, other_win = 1'b0;
  logic [7:0]  gnt_n;
  logic        hicls_gnt_n, long_gnt_n, busy_out_n;
  logic [2:0]  arb_req_n;

  int nvec = 0, nbad = 0;
  int m_hi [ND], m_lo [ND], m_rov [ND];

  always #4 clk = ~clk;

  prio_req_arbiter u0 (.clk(clk), .rst(rst), .req_n(req_n), .dev_cfg(dev_cfg),
    .busy_in_n(busy_in_n), .stop_n(stop_n), .other_win(other_win), .gnt_n(gnt_n),
    .hicls_gnt_n(hicls_gnt_n), .long_gnt_n(long_gnt_n), .busy_out_n(busy_out_n),
    .arb_req_n(arb_req_n));

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int d = 0; d < ND; d++) begin m_hi[d] = 0; m_lo[d] = 0; m_rov[d] = 0; end
  endtask

  // bench model: count a one-cycle request word
  task automatic model_add(input logic [23:0] w);
    for (int d = 0; d < ND; d++) begin
      logic [2:0] c;
      c = w[3*d +: 3];
      if (c == C_HI && CFG_TAB[d][8]) m_hi[d] = (m_hi[d] < 3) ? m_hi[d] + 1 : 3;
      else if (c == C_HI || c == C_LO) m_lo[d] = (m_lo[d] < 3) ? m_lo[d] + 1 : 3;
    end
  endtask

  task automatic predict(output int dev, output int hi, output int lng, output int pr);
    int lv [ND]; int cl [ND]; int lg [ND];
    pr = 7; dev = -1;
    for (int d = 0; d < ND; d++) begin
      if (CFG_TAB[d][8] && m_hi[d] > 0) begin
        lv[d] = int'(CFG_TAB[d][2:0]); cl[d] = 1; lg[d] = int'(CFG_TAB[d][6]);
      end else if (m_lo[d] > 0) begin
        lv[d] = int'(CFG_TAB[d][5:3]); cl[d] = 0; lg[d] = int'(CFG_TAB[d][7]);
      end else begin
        lv[d] = 7; cl[d] = 0; lg[d] = 0;
      end
      if (lv[d] < pr) pr = lv[d];
    end
    for (int d = 0; d < ND; d++) if (dev < 0 && lv[d] == pr && d > m_rov[pr]) dev = d;
    for (int d = 0; d < ND; d++) if (dev < 0 && lv[d] == pr) dev = d;
    hi = cl[dev]; lng = lg[dev];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int dev, hi, lng, pr, cnt_own, cnt_other;
    for (int d = 0; d < ND; d++) dev_cfg[9*d +: 9] = CFG_TAB[d];
    do_reset();
    // R12 reset state
    chk("R12 gnt_n reset", int'(gnt_n), 255);
    chk("R12 hicls reset", int'(hicls_gnt_n), 1);
    chk("R12 long reset", int'(long_gnt_n), 1);
    chk("R12 busy reset", int'(busy_out_n), 1);
    chk("R12 arb_req reset", int'(arb_req_n), 0);

    // table walk: R1 R3 R4 R5 R6 R8 R9
    for (int v = 0; v < NV; v++) begin
      req_n = VEC[v]; model_add(VEC[v]);
      @(posedge clk); @(negedge clk); req_n = IDLE_W;
      repeat (3) @(posedge clk);
      predict(dev, hi, lng, pr);
      while (pr < 6) begin
        @(negedge clk);
        chk("R5 R6 R8 grant", int'(gnt_n), 255 ^ (1 << dev));
        chk("R9 class", int'(hicls_gnt_n), 1 - hi);
        chk("R9 long", int'(long_gnt_n), 1 - lng);
        if (hi != 0) m_hi[dev]--; else m_lo[dev]--;
        m_rov[pr] = dev;
        @(posedge clk); @(negedge clk);
        chk("R8 grant held", int'(gnt_n), 255 ^ (1 << dev));
        @(posedge clk);
        predict(dev, hi, lng, pr);
      end
      @(negedge clk);
      chk("R2 R7 drained", int'(gnt_n), 255);
      cycles(3);
    end

    // R2 saturation with stop in force (R7)
    do_reset();
    stop_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      req_n = {{5{C_ID}}, C_LO, C_ID, C_ID}; @(posedge clk); @(negedge clk);
    end
    req_n = IDLE_W;
    cycles(6);
    chk("R7 stop blocks", int'(gnt_n), 255);
    stop_n = 1'b1;
    cnt_own = 0; cnt_other = 0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); @(negedge clk);
      if (!gnt_n[2]) cnt_own++;
      if ((gnt_n | 8'h04) != 8'hFF) cnt_other++;
    end
    chk("R2 saturated grant cycles", cnt_own, 6);
    chk("R2 no other grant", cnt_other, 0);

    // R7 busy_in blocks, R10 long busy, R7 hold under stop
    do_reset();
    busy_in_n = 1'b0;
    req_n = {{7{C_ID}}, C_HI}; @(posedge clk); @(negedge clk); req_n = IDLE_W;
    cycles(8);
    chk("R7 busy_in blocks", int'(gnt_n), 255);
    busy_in_n = 1'b1;
    cycles(2);
    chk("R7 grant after busy_in", int'(gnt_n), 8'hFE);
    chk("R9 high class", int'(hicls_gnt_n), 0);
    chk("R10 busy grant cycle", int'(busy_out_n), 0);
    stop_n = 1'b0;
    cycles(1); chk("R10 busy +1", int'(busy_out_n), 0);
    cycles(1); chk("R10 busy +2", int'(busy_out_n), 0);
    cycles(1); chk("R10 busy ends", int'(busy_out_n), 1);
    cycles(5);
    chk("R7 grant held under stop", int'(gnt_n), 8'hFE);
    stop_n = 1'b1;

    // R10 short grant leaves busy high
    do_reset();
    req_n = {{5{C_ID}}, C_LO, C_ID, C_ID}; @(posedge clk); @(negedge clk); req_n = IDLE_W;
    cnt_own = 0; cnt_other = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); @(negedge clk);
      if (!busy_out_n) cnt_other++;
      if (!gnt_n[2]) cnt_own++;
    end
    chk("R10 short grant seen", cnt_own, 2);
    chk("R10 short no busy", cnt_other, 0);

    // R7 other contender blocks
    do_reset();
    other_win = 1'b1;
    req_n = {{4{C_ID}}, C_HI, {3{C_ID}}}; @(posedge clk); @(negedge clk); req_n = IDLE_W;
    cycles(10);
    chk("R7 other_win blocks", int'(gnt_n), 255);
    other_win = 1'b0;
    cycles(1);
    chk("R7 grant after other_win", int'(gnt_n), 8'hF7);

    // R11 hold level, R1 ignored code, R12 reset clears counts
    do_reset();
    stop_n = 1'b0;
    req_n = {{3{C_ID}}, C_SZ, {4{C_ID}}}; @(posedge clk); @(negedge clk); req_n = IDLE_W;
    cycles(4);
    chk("R11 seize level", int'(arb_req_n), 3'b001);
    req_n = {{3{C_ID}}, C_RL, {4{C_ID}}}; @(posedge clk); @(negedge clk); req_n = IDLE_W;
    cycles(4);
    chk("R11 release level", int'(arb_req_n), 3'b000);
    req_n = {C_ID, C_BAD, {6{C_ID}}}; @(posedge clk); @(negedge clk); req_n = IDLE_W;
    cycles(4);
    chk("R1 unused code ignored", int'(arb_req_n), 3'b000);
    req_n = {{2{C_ID}}, C_LO, C_SZ, {4{C_ID}}}; @(posedge clk); @(negedge clk); req_n = IDLE_W;
    cycles(4);
    chk("R11 request beats hold", int'(arb_req_n), 3'b100);
    do_reset();
    stop_n = 1'b1;
    cycles(10);
    chk("R12 counts cleared", int'(gnt_n), 255);
    chk("R12 hold cleared", int'(arb_req_n), 3'b000);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule